// File: doc/BRIEF.md
# Programmable Two-Sample-per-Chip BPSK Despreading Correlator

This block despreads a direct-sequence BPSK signal with a sliding matched filter. Complex baseband samples arrive as separate I and Q words at twice the chip rate. Each channel has its own delay line. Taps sit on every second stage of that line and are weighted +1 or -1 by the programmed receive spreading code. Both channels always use the same code. A full correlation sum for each channel comes out for every accepted sample, so a later symbol timing stage can search the stream of sums for the peak.

The receive code word and a 2-bit length select are applied as level inputs. The length select picks 11, 13, 15 or 16 chips per symbol, and taps past the selected length contribute nothing. A separate transmit code word and its own 2-bit length select are registered and presented to a spreader, so each link direction can use different spreading. When the receive code or length changes, the delay lines are flushed, so stale samples never combine with a new code.

Top module: `pn_correlator`

## Requirements
- R1: The length select maps 2'b00 to 11 chips, 2'b01 to 13, 2'b10 to 15 and 2'b11 to 16. Only code bits 0 to N-1 of the receive code contribute to the sums, where N is the selected length.
- R2: Chip k (code bit k) multiplies the sample accepted 2k samples before the newest accepted sample. Samples at odd delays do not contribute.
- R3: A code bit of 1 weights its sample by +1 and a bit of 0 weights it by -1. The I and Q sums use the same code and length.
- R4: A sample accepted on a clock edge with `smp_valid` high produces `corr_valid` high exactly two edges later. The sums then cover the window ending with that sample. `corr_valid` is low in every other cycle, and the sums hold their value while it is low.
- R5: On any edge where the receive code or length input differs from the value held since the previous edge, the new setting takes effect, both delay lines are cleared to zero, and a sample presented on that edge is dropped and produces no output.
- R6: The transmit code and transmit length select are registered on every edge. They appear one edge later on `tx_code_o` and on `tx_chips_o`, which gives the decoded chip count with the R1 mapping. Transmit settings never disturb the receive path, and receive settings never change the transmit outputs.
- R7: Sums are signed and wide enough for 32 full-scale products. With 16 chips, every sample at -32 and an all-zero code gives +512 with no wrap.
- R8: Reset (synchronous, active high) clears the delay lines, drives `corr_valid` low and both sums to zero, and sets `tx_code_o` to 0 and `tx_chips_o` to 11. The active receive setting becomes code 0, length select 2'b00.
- R9: While `smp_valid` is low the delay lines hold their contents, so a sample arriving after a gap correlates with the samples before the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one per half chip |
| smp_i | input | 6 | Signed I sample |
| smp_q | input | 6 | Signed Q sample |
| rx_code | input | 16 | Receive spreading code, bit k is chip k |
| rx_len_sel | input | 2 | Receive length select |
| tx_code | input | 16 | Transmit spreading code |
| tx_len_sel | input | 2 | Transmit length select |
| corr_valid | output | 1 | Correlation result strobe |
| corr_i | output | 12 | Signed I correlation sum |
| corr_q | output | 12 | Signed Q correlation sum |
| tx_code_o | output | 16 | Registered transmit code |
| tx_chips_o | output | 5 | Decoded transmit chip count |

## Verification
Single-sample impulses on I alone, then on Q alone, walk through the delay line. They show whether each tap sits at an even delay and whether the sign matches the code bit, and they would expose a tap at an odd delay or a swapped code order. Full-scale negative samples with a 16-chip all-zero code test sum width and sign extension. Random samples with random gaps and occasional changes to code and length test the length masking at each of the four settings, the flush and the dropped sample. Transmit settings are changed while receive traffic runs, which separates the two configuration paths.

// File: rtl/pn_corr_pkg.sv
package pn_corr_pkg;

  // decode of a 2-bit spreading length select into chips per symbol
  function automatic logic [4:0] chips_of(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd11;
      2'b01:   return 5'd13;
      2'b10:   return 5'd15;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/pn_cfg_reg.sv
module pn_cfg_reg #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        len_i,
  output logic [CODE_W-1:0] code_q,
  output logic [1:0]        len_q,
  output logic              changed
);
  assign changed = (code_i != code_q) || (len_i != len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      len_q  <= 2'b00;
    end else if (changed) begin
      code_q <= code_i;
      len_q  <= len_i;
    end
  end
endmodule

// File: rtl/pn_tap_line.sv
module pn_tap_line #(
  parameter int W     = 6,
  parameter int DEPTH = 31
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      shift,
  input  logic [W-1:0]              din,
  output logic [DEPTH-1:0][W-1:0]   taps_o
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      taps_o <= '0;
    end else if (shift) begin
      taps_o[0] <= din;
      for (int i = 1; i < DEPTH; i++) taps_o[i] <= taps_o[i-1];
    end
  end
endmodule

// File: rtl/pn_tap_sum.sv
module pn_tap_sum #(
  parameter int W     = 6,
  parameter int CHIPS = 16,
  parameter int SPC   = 2,
  parameter int DEPTH = 31,
  parameter int SUM_W = 12
) (
  input  logic [DEPTH-1:0][W-1:0] taps_i,
  input  logic [CHIPS-1:0]        code_i,
  input  logic [4:0]              nchips_i,
  output logic [SUM_W-1:0]        sum_o
);
  logic signed [SUM_W-1:0] acc;
  logic signed [SUM_W-1:0] term;

  always_comb begin
    acc  = '0;
    term = '0;
    for (int k = 0; k < CHIPS; k++) begin
      if (k < int'(nchips_i)) begin
        term = {{(SUM_W-W){taps_i[SPC*k][W-1]}}, taps_i[SPC*k]};
        if (code_i[k]) acc = acc + term;
        else           acc = acc - term;
      end
    end
    sum_o = acc;
  end
endmodule

// File: rtl/pn_correlator.sv
module pn_correlator #(
  parameter int SAMPLE_W  = 6,
  parameter int MAX_CHIPS = 16,
  parameter int SPC       = 2,
  parameter int ACC_TERMS = 32,
  localparam int DEPTH    = SPC*(MAX_CHIPS-1) + 1,
  localparam int SUM_W    = SAMPLE_W + $clog2(ACC_TERMS) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic [SAMPLE_W-1:0]  smp_i,
  input  logic [SAMPLE_W-1:0]  smp_q,
  input  logic [MAX_CHIPS-1:0] rx_code,
  input  logic [1:0]           rx_len_sel,
  input  logic [MAX_CHIPS-1:0] tx_code,
  input  logic [1:0]           tx_len_sel,
  output logic                 corr_valid,
  output logic [SUM_W-1:0]     corr_i,
  output logic [SUM_W-1:0]     corr_q,
  output logic [MAX_CHIPS-1:0] tx_code_o,
  output logic [4:0]           tx_chips_o
);
  import pn_corr_pkg::*;

  logic [MAX_CHIPS-1:0] rx_code_act;
  logic [1:0]           rx_len_act;
  logic                 rx_chg;
  logic                 shift_en;
  logic                 stage_vld;
  logic [4:0]           rx_chips;

  logic [1:0][SAMPLE_W-1:0] samp;
  logic [1:0][SUM_W-1:0]    sums;

  pn_cfg_reg #(.CODE_W(MAX_CHIPS)) u_rx_cfg (
    .clk(clk), .rst(rst), .code_i(rx_code), .len_i(rx_len_sel),
    .code_q(rx_code_act), .len_q(rx_len_act), .changed(rx_chg)
  );

  assign rx_chips = chips_of(rx_len_act);
  assign shift_en = smp_valid && !rx_chg;
  assign samp[0]  = smp_i;
  assign samp[1]  = smp_q;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [DEPTH-1:0][SAMPLE_W-1:0] taps;

    pn_tap_line #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_line (
      .clk(clk), .rst(rst), .clear(rx_chg), .shift(shift_en),
      .din(samp[ch]), .taps_o(taps)
    );

    pn_tap_sum #(.W(SAMPLE_W), .CHIPS(MAX_CHIPS), .SPC(SPC),
                 .DEPTH(DEPTH), .SUM_W(SUM_W)) u_sum (
      .taps_i(taps), .code_i(rx_code_act), .nchips_i(rx_chips),
      .sum_o(sums[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) stage_vld <= 1'b0;
    else     stage_vld <= shift_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_valid <= 1'b0;
      corr_i     <= '0;
      corr_q     <= '0;
    end else begin
      corr_valid <= stage_vld;
      if (stage_vld) begin
        corr_i <= sums[0];
        corr_q <= sums[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_code_o  <= '0;
      tx_chips_o <= 5'd11;
    end else begin
      tx_code_o  <= tx_code;
      tx_chips_o <= chips_of(tx_len_sel);
    end
  end
endmodule

// File: rtl/pn_correlator_chk.sv
module pn_correlator_chk #(
  parameter int SAMPLE_W  = 6,
  parameter int MAX_CHIPS = 16,
  parameter int SUM_W     = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 smp_valid,
  input logic                 rx_chg,
  input logic                 stage_vld,
  input logic                 corr_valid,
  input logic [SUM_W-1:0]     corr_i,
  input logic [SUM_W-1:0]     corr_q,
  input logic [MAX_CHIPS-1:0] tx_code,
  input logic [1:0]           tx_len_sel,
  input logic [MAX_CHIPS-1:0] tx_code_o,
  input logic [4:0]           tx_chips_o
);
  localparam int LIMIT = MAX_CHIPS * (2 ** (SAMPLE_W-1));

  // R4
  out_from_sample_chk: assert property (@(posedge clk) disable iff (rst)
    corr_valid |-> $past(smp_valid, 2));

  // R5
  flush_drop_chk: assert property (@(posedge clk) disable iff (rst)
    rx_chg |=> !stage_vld);

  // R7
  sum_range_chk: assert property (@(posedge clk) disable iff (rst)
    ($signed(corr_i) <= LIMIT) && ($signed(corr_i) >= -LIMIT) &&
    ($signed(corr_q) <= LIMIT) && ($signed(corr_q) >= -LIMIT));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(tx_code) && $stable(tx_len_sel)) |=>
      ($stable(tx_code_o) && $stable(tx_chips_o)));

  // R1
  tx_len_code_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_chips_o == 5'd11) || (tx_chips_o == 5'd13) ||
    (tx_chips_o == 5'd15) || (tx_chips_o == 5'd16));
endmodule

bind pn_correlator pn_correlator_chk #(
  .SAMPLE_W(SAMPLE_W), .MAX_CHIPS(MAX_CHIPS), .SUM_W(SUM_W)
) chk_i (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .rx_chg(rx_chg),
  .stage_vld(stage_vld), .corr_valid(corr_valid), .corr_i(corr_i),
  .corr_q(corr_q), .tx_code(tx_code), .tx_len_sel(tx_len_sel),
  .tx_code_o(tx_code_o), .tx_chips_o(tx_chips_o)
);

// File: tb/pn_correlator_test.sv
`timescale 1ns/1ps
module pn_correlator_test;
  localparam int CLK_NS = 20;
  localparam int DEPTH  = 31;

  logic        clk = 1'b0;
  logic        rst;
  logic        smp_valid;
  logic [5:0]  smp_i, smp_q;
  logic [15:0] rx_code, tx_code;
  logic [1:0]  rx_len_sel, tx_len_sel;
  logic        corr_valid;
  logic [11:0] corr_i, corr_q;
  logic [15:0] tx_code_o;
  logic [4:0]  tx_chips_o;

  always #(CLK_NS/2) clk = ~clk;

  pn_correlator uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .rx_code(rx_code), .rx_len_sel(rx_len_sel), .tx_code(tx_code),
    .tx_len_sel(tx_len_sel), .corr_valid(corr_valid), .corr_i(corr_i),
    .corr_q(corr_q), .tx_code_o(tx_code_o), .tx_chips_o(tx_chips_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  int        m_dl_i [DEPTH];
  int        m_dl_q [DEPTH];
  bit [15:0] m_code;
  bit [1:0]  m_len;
  bit        m_v1;
  bit        e_valid;
  int        e_i, e_q;
  bit [15:0] e_tx_code;
  int        e_tx_chips;

  function automatic int n_chips(input bit [1:0] s);
    case (s)
      2'b00: return 11;
      2'b01: return 13;
      2'b10: return 15;
      default: return 16;
    endcase
  endfunction

  function automatic int model_sum(input bit q);
    int acc = 0;
    for (int k = 0; k < n_chips(m_len); k++) begin
      int s = q ? m_dl_q[2*k] : m_dl_i[2*k];
      acc += m_code[k] ? s : -s;
    end
    return acc;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin m_dl_i[i] = 0; m_dl_q[i] = 0; end
    m_code = '0; m_len = 2'b00; m_v1 = 0; e_valid = 0; e_i = 0; e_q = 0;
    e_tx_code = '0; e_tx_chips = 11;
  endtask

  // drive at negedge, model the next edge, check at the following negedge
  task automatic step(input string req, input bit v, input int si, input int sq,
                      input bit [15:0] rc, input bit [1:0] rl,
                      input bit [15:0] tc, input bit [1:0] tl);
    bit nv;
    smp_valid = v; smp_i = 6'(si); smp_q = 6'(sq);
    rx_code = rc; rx_len_sel = rl; tx_code = tc; tx_len_sel = tl;
    nv = m_v1;
    if (m_v1) begin e_i = model_sum(0); e_q = model_sum(1); end
    if (rc != m_code || rl != m_len) begin
      for (int i = 0; i < DEPTH; i++) begin m_dl_i[i] = 0; m_dl_q[i] = 0; end
      m_code = rc; m_len = rl; m_v1 = 0;
    end else begin
      m_v1 = v;
      if (v) begin
        for (int i = DEPTH-1; i > 0; i--) begin
          m_dl_i[i] = m_dl_i[i-1]; m_dl_q[i] = m_dl_q[i-1];
        end
        m_dl_i[0] = si; m_dl_q[0] = sq;
      end
    end
    e_valid = nv;
    e_tx_code = tc; e_tx_chips = n_chips(tl);
    @(posedge clk);
    @(negedge clk);
    chk(req, "corr_valid", int'(corr_valid), int'(e_valid));
    if (e_valid) begin
      chk(req, "corr_i", int'($signed(corr_i)), e_i);
      chk(req, "corr_q", int'($signed(corr_q)), e_q);
    end
    chk("R6", "tx_code_o", int'(tx_code_o), int'(e_tx_code));
    chk("R6", "tx_chips_o", int'(tx_chips_o), e_tx_chips);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit [15:0] rc, tc;
    bit [1:0]  rl, tl;
    void'($urandom(32'h5EED_1234));
    rst = 1; smp_valid = 0; smp_i = 0; smp_q = 0;
    rx_code = 0; rx_len_sel = 0; tx_code = 0; tx_len_sel = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk("R8", "corr_valid", int'(corr_valid), 0);
    chk("R8", "corr_i", int'($signed(corr_i)), 0);
    chk("R8", "corr_q", int'($signed(corr_q)), 0);
    chk("R8", "tx_code_o", int'(tx_code_o), 0);
    chk("R8", "tx_chips_o", int'(tx_chips_o), 11);
    rst = 0;

    // R5: code change with a sample present drops it
    rc = 16'hA5C3; rl = 2'b00; tc = 16'h0F0F; tl = 2'b11;
    step("R5", 1, 31, -7, rc, rl, tc, tl);
    step("R5", 0, 0, 0, rc, rl, tc, tl);
    step("R5", 0, 0, 0, rc, rl, tc, tl);

    // R2/R3: impulse on I then on Q walks through the taps
    step("R2", 1, 17, 0, rc, rl, tc, tl);
    for (int n = 0; n < 24; n++) step("R2", 1, 0, 0, rc, rl, tc, tl);
    step("R3", 1, 0, -9, rc, rl, tc, tl);
    for (int n = 0; n < 24; n++) step("R3", 1, 0, 0, rc, rl, tc, tl);

    // R1: each length with a constant sample stream
    for (int L = 0; L < 4; L++) begin
      rl = 2'(L);
      for (int n = 0; n < 36; n++) step("R1", 1, 5, -3, 16'hFFFF, rl, tc, tl);
    end

    // R7: full-scale negative, all-zero code, 16 chips
    for (int n = 0; n < 36; n++) step("R7", 1, -32, -32, 16'h0000, 2'b11, tc, tl);

    // R9: gaps keep the line
    for (int n = 0; n < 20; n++)
      step("R9", (n % 3) == 0, n - 10, 10 - n, 16'h0000, 2'b11, tc, tl);

    // R6: transmit changes during receive traffic
    for (int n = 0; n < 20; n++)
      step("R6", 1, n, -n, 16'h0000, 2'b11, 16'(n * 97), 2'(n));

    // R4: random traffic with occasional setting changes
    rc = 16'h3C5A; rl = 2'b01;
    for (int n = 0; n < 1500; n++) begin
      if (($urandom % 40) == 0) begin rc = 16'($urandom); rl = 2'($urandom); end
      if (($urandom % 25) == 0) begin tc = 16'($urandom); tl = 2'($urandom); end
      step("R4", ($urandom % 4) != 0, int'($urandom % 64) - 32,
           int'($urandom % 64) - 32, rc, rl, tc, tl);
    end
    step("R4", 0, 0, 0, rc, rl, tc, tl);
    step("R4", 0, 0, 0, rc, rl, tc, tl);
    finish_run();
  end
endmodule